// File: doc/BRIEF.md
# ARINC Receive Word Buffer with Repeater Forwarding

This block holds completed 32-bit words delivered by an upstream serial decoder until a host collects them. Each word arrives with a one-cycle valid strobe and goes into a small first-in first-out store; a data-ready flag tells the host that at least one word is waiting. The host reads the oldest word as two 16-bit halves. A select input picks the half shown on the data output, and a read strobe marks a half as taken. The word leaves the store only once both halves have been taken.

When repeater mode is on, each half the host reads is also presented, one cycle later, on a load port that feeds an external transmit FIFO. The received word is then sent out again without the host writing it a second time. The transmit side always loads the lower half first, so in this mode the host must read the lower half first. An upper half read first is not forwarded, and it sets a sticky order-error flag.

A separate loopback path serves self-test. When the active-low test control is low, the transmitter's serial output replaces both receiver line inputs. Receiver 1 gets it as is and receiver 2 gets it inverted. The receive path has no other link to the transmitter. If a word arrives while the store is full and no word leaves in that cycle, the new word overwrites the most recently stored entry and the read position stays where it was.

Top module: `arx_rxbuf`

The read tracker is a three-state machine:
- `HALF_NONE`: no half of the oldest word has been taken.
- `HALF_LO`: only the lower half has been taken.
- `HALF_HI`: only the upper half has been taken.

Its transitions are:
- Start-lower: from `HALF_NONE` to `HALF_LO`, on a lower read.
- Start-upper: from `HALF_NONE` to `HALF_HI`, on an upper read.
- Complete: from `HALF_LO` to `HALF_NONE` on an upper read, or from `HALF_HI` to `HALF_NONE` on a lower read. Either one pops the word.
- Re-read: the machine stays in `HALF_LO` or `HALF_HI` when the same half is read again.

## Requirements
- R1: After reset, data_ready, tx_load and order_err are all low.
- R2: data_ready is high exactly when the store holds at least one word, and words are presented in the order they arrived.
- R3: host_data shows bits 15:0 of the oldest word when host_sel is 0, and bits 31:16 of that word when host_sel is 1.
- R4: In normal mode either half may be read first. The oldest word is removed only on the clock edge that completes the second, different half. Reading the same half again does not remove it.
- R5: In repeater mode, a lower read from `HALF_NONE` followed by an upper read gives two one-cycle tx_load pulses, each in the cycle after its read. tx_data carries the lower half on the first pulse and the upper half on the second.
- R6: In repeater mode, an upper read from `HALF_NONE` gives no tx_load pulse and sets order_err, which stays high until reset. The lower read that completes that word removes it, also without a tx_load pulse.
- R7: With rpt_en low, tx_load never pulses.
- R8: A word that arrives while the store is full, with no word leaving in that cycle, replaces the most recently stored entry. The older entries, their order and the read position are unchanged.
- R9: A read strobe while data_ready is low has no effect: no pulse, no state change, and the next word is read normally.
- R10: With selftest_n low, rx1_bit equals tx_serial and rx2_bit equals its inverse. With selftest_n high, rx1_bit follows line1_in and rx2_bit follows line2_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a completed word is on rx_word |
| rx_word | input | 32 | Completed received word |
| host_rd | input | 1 | Host takes the half chosen by host_sel at this edge |
| host_sel | input | 1 | 0 selects the lower half, 1 selects the upper half |
| rpt_en | input | 1 | Repeater mode enable |
| host_data | output | 16 | Selected half of the oldest word |
| data_ready | output | 1 | Store not empty |
| tx_load | output | 1 | Load strobe toward the transmit FIFO |
| tx_data | output | 16 | Half-word toward the transmit FIFO |
| order_err | output | 1 | Sticky: upper half read first in repeater mode |
| selftest_n | input | 1 | Low routes transmitter serial data into the receivers |
| tx_serial | input | 1 | Transmitter serial output |
| line1_in | input | 1 | Receiver 1 line bit |
| line2_in | input | 1 | Receiver 2 line bit |
| rx1_bit | output | 1 | Bit sent to receiver 1 |
| rx2_bit | output | 1 | Bit sent to receiver 2 |

## Verification
Reads are exercised in normal mode in three orders: upper then lower, a repeated upper before the lower, and lower then upper. Together they show that a word leaves only when both distinct halves have been taken, and never on a repeat. In repeater mode, the correct order is contrasted with upper-first, which separates forwarded halves from suppressed ones and shows that the error flag persists. Five words pushed into a four-entry store show which entry an overflow replaces. A read on an empty store shows that stray strobes leave no trace. Loopback is driven with both serial levels under test control and distinct line levels without it.

// File: rtl/arx_pkg.sv
package arx_pkg;
    typedef enum logic [1:0] {
        HALF_NONE = 2'd0,
        HALF_LO   = 2'd1,
        HALF_HI   = 2'd2
    } half_st_t;
endpackage

// File: rtl/arx_rx_fifo.sv
module arx_rx_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              not_empty,
    output logic              full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_pop, do_push, do_ovw;

    function automatic logic [AW-1:0] step_up(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [AW-1:0] step_down(input logic [AW-1:0] p);
        return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
    endfunction

    assign not_empty = (count != '0);
    assign full      = (count == CW'(DEPTH));
    assign head      = mem[rd_ptr];
    assign do_pop    = pop && not_empty;
    assign do_push   = push && (!full || do_pop);
    assign do_ovw    = push && full && !do_pop;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end else if (do_ovw) begin
            mem[step_down(wr_ptr)] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step_up(wr_ptr);
            if (do_pop)  rd_ptr <= step_up(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/arx_rd_ctrl.sv
module arx_rd_ctrl
    import arx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic sel,
    input  logic rpt,
    input  logic avail,
    output logic pop,
    output logic fwd,
    output logic err_set
);
    half_st_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HALF_NONE;
        else        state <= nxt;
    end

    always_comb begin
        nxt     = state;
        pop     = 1'b0;
        fwd     = 1'b0;
        err_set = 1'b0;
        if (rd && avail) begin
            unique case (state)
                HALF_NONE: begin
                    if (!sel) begin
                        nxt = HALF_LO;
                        fwd = rpt;
                    end else begin
                        nxt     = HALF_HI;
                        err_set = rpt;
                    end
                end
                HALF_LO: begin
                    if (sel) begin
                        nxt = HALF_NONE;
                        pop = 1'b1;
                        fwd = rpt;
                    end
                end
                HALF_HI: begin
                    if (!sel) begin
                        nxt = HALF_NONE;
                        pop = 1'b1;
                    end
                end
                default: nxt = HALF_NONE;
            endcase
        end
    end
endmodule

// File: rtl/arx_loopback.sv
module arx_loopback (
    input  logic selftest_n,
    input  logic tx_serial,
    input  logic line1_in,
    input  logic line2_in,
    output logic rx1_bit,
    output logic rx2_bit
);
    always_comb begin
        if (!selftest_n) begin
            rx1_bit = tx_serial;
            rx2_bit = ~tx_serial;
        end else begin
            rx1_bit = line1_in;
            rx2_bit = line2_in;
        end
    end
endmodule

// File: rtl/arx_rxbuf.sv
module arx_rxbuf #(
    parameter int HALF_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [2*HALF_W-1:0] rx_word,
    input  logic              host_rd,
    input  logic              host_sel,
    input  logic              rpt_en,
    output logic [HALF_W-1:0] host_data,
    output logic              data_ready,
    output logic              tx_load,
    output logic [HALF_W-1:0] tx_data,
    output logic              order_err,
    input  logic              selftest_n,
    input  logic              tx_serial,
    input  logic              line1_in,
    input  logic              line2_in,
    output logic              rx1_bit,
    output logic              rx2_bit
);
    localparam int WORD_W = 2 * HALF_W;

    logic [WORD_W-1:0] head;
    logic              not_empty, full_unused, pop, fwd, err_set;

    arx_rx_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid),
        .push_data (rx_word),
        .pop       (pop),
        .head      (head),
        .not_empty (not_empty),
        .full      (full_unused)
    );

    arx_rd_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (host_rd),
        .sel     (host_sel),
        .rpt     (rpt_en),
        .avail   (not_empty),
        .pop     (pop),
        .fwd     (fwd),
        .err_set (err_set)
    );

    arx_loopback u_loop (
        .selftest_n (selftest_n),
        .tx_serial  (tx_serial),
        .line1_in   (line1_in),
        .line2_in   (line2_in),
        .rx1_bit    (rx1_bit),
        .rx2_bit    (rx2_bit)
    );

    assign host_data  = host_sel ? head[WORD_W-1:HALF_W] : head[HALF_W-1:0];
    assign data_ready = not_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_load   <= 1'b0;
            tx_data   <= '0;
            order_err <= 1'b0;
        end else begin
            tx_load   <= fwd;
            if (fwd) tx_data <= host_data;
            order_err <= order_err | err_set;
        end
    end
endmodule

// File: rtl/arx_rxbuf_chk.sv
module arx_rxbuf_chk #(
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              host_rd,
    input logic              rpt_en,
    input logic [HALF_W-1:0] host_data,
    input logic              data_ready,
    input logic              tx_load,
    input logic [HALF_W-1:0] tx_data,
    input logic              order_err,
    input logic              selftest_n,
    input logic              rx1_bit,
    input logic              rx2_bit
);
    // R7
    norpt_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !rpt_en) |=> !tx_load);
    // R5
    load_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(host_rd));
    // R5
    load_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (tx_data == $past(host_data)));
    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |=> order_err);
    // R2
    ready_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> data_ready);
    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_ready && !rx_valid) |=> (!data_ready && !tx_load));
    // R10
    loop_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !selftest_n |-> (rx1_bit != rx2_bit));
endmodule

bind arx_rxbuf arx_rxbuf_chk #(.HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .host_rd    (host_rd),
    .rpt_en     (rpt_en),
    .host_data  (host_data),
    .data_ready (data_ready),
    .tx_load    (tx_load),
    .tx_data    (tx_data),
    .order_err  (order_err),
    .selftest_n (selftest_n),
    .rx1_bit    (rx1_bit),
    .rx2_bit    (rx2_bit)
);

// File: tb/sim_arx_rxbuf.sv
module sim_arx_rxbuf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_word = '0;
    logic        host_rd = 1'b0, host_sel = 1'b0, rpt_en = 1'b0;
    logic [15:0] host_data, tx_data;
    logic        data_ready, tx_load, order_err;
    logic        selftest_n = 1'b1, tx_serial = 1'b0, line1_in = 1'b0, line2_in = 1'b0;
    logic        rx1_bit, rx2_bit;

    int checks = 0;
    int errors = 0;
    logic [15:0] txq[$];

    always #5 clk = ~clk;

    arx_rxbuf u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_word  = w;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Driver: checks the half shown, queues the expected forwarded half.
    task automatic read_half(input logic sel, input logic [15:0] exp, input bit fwd, input string req);
        @(negedge clk);
        host_rd  = 1'b1;
        host_sel = sel;
        #1;
        chk(host_data == exp, req, {16'h0, host_data}, {16'h0, exp});
        if (fwd) txq.push_back(exp);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Monitor: every load pulse must match the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n && tx_load) begin
            if (txq.size() == 0) begin
                chk(1'b0, "R7 unexpected tx_load", {16'h0, tx_data}, 32'h0);
            end else begin
                logic [15:0] e;
                e = txq.pop_front();
                chk(tx_data == e, "R5 tx_data", {16'h0, tx_data}, {16'h0, e});
            end
        end
    end

    initial begin
        #(200000 * 10);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!data_ready, "R1 data_ready", {31'h0, data_ready}, 32'h0);
        chk(!tx_load,    "R1 tx_load",    {31'h0, tx_load},    32'h0);
        chk(!order_err,  "R1 order_err",  {31'h0, order_err},  32'h0);

        // R9: strobes on an empty store
        rpt_en = 1'b1;
        @(negedge clk); host_rd = 1'b1; host_sel = 1'b1;
        @(negedge clk); host_rd = 1'b0;
        @(negedge clk);
        chk(!data_ready && !order_err && !tx_load, "R9 empty read",
            {29'h0, data_ready, order_err, tx_load}, 32'h0);
        rpt_en = 1'b0;

        // R2 / R3 / R4: normal mode, upper first with a repeat
        push_word(32'hA1A2_B1B2);
        push_word(32'hC3C4_D3D4);
        chk(data_ready, "R2 ready", {31'h0, data_ready}, 32'h1);
        read_half(1'b1, 16'hA1A2, 1'b0, "R3 upper");
        read_half(1'b1, 16'hA1A2, 1'b0, "R4 reread keeps word");
        read_half(1'b0, 16'hB1B2, 1'b0, "R4 lower completes");
        host_sel = 1'b0; #1;
        chk(host_data == 16'hD3D4, "R2 next word", {16'h0, host_data}, 32'hD3D4);
        read_half(1'b0, 16'hD3D4, 1'b0, "R4 lower first");
        read_half(1'b1, 16'hC3C4, 1'b0, "R4 upper completes");
        chk(!data_ready, "R2 empty", {31'h0, data_ready}, 32'h0);

        // R5: repeater, correct order
        rpt_en = 1'b1;
        push_word(32'h1234_5678);
        read_half(1'b0, 16'h5678, 1'b1, "R5 lower");
        read_half(1'b1, 16'h1234, 1'b1, "R5 upper");
        chk(!order_err && !data_ready, "R5 no error, popped",
            {30'h0, order_err, data_ready}, 32'h0);

        // R6: repeater, upper first
        push_word(32'h9ABC_DEF0);
        read_half(1'b1, 16'h9ABC, 1'b0, "R6 upper first");
        chk(order_err, "R6 error set", {31'h0, order_err}, 32'h1);
        read_half(1'b0, 16'hDEF0, 1'b0, "R6 lower completes");
        chk(!data_ready, "R6 popped", {31'h0, data_ready}, 32'h0);
        repeat (3) @(negedge clk);
        chk(order_err, "R6 sticky", {31'h0, order_err}, 32'h1);
        rpt_en = 1'b0;

        // R8: overflow replaces newest entry
        for (int i = 0; i < 5; i++) push_word({16'hE000 + 16'(i), 16'h0F00 + 16'(i)});
        for (int i = 0; i < 4; i++) begin
            logic [15:0] k;
            k = (i == 3) ? 16'd4 : 16'(i);
            read_half(1'b0, 16'h0F00 + k, 1'b0, "R8 lower");
            read_half(1'b1, 16'hE000 + k, 1'b0, "R8 upper");
        end
        chk(!data_ready, "R8 drained", {31'h0, data_ready}, 32'h0);

        // R10: loopback
        selftest_n = 1'b0; tx_serial = 1'b1; line1_in = 1'b0; line2_in = 1'b1; #1;
        chk(rx1_bit && !rx2_bit, "R10 loop one", {30'h0, rx1_bit, rx2_bit}, 32'h2);
        tx_serial = 1'b0; #1;
        chk(!rx1_bit && rx2_bit, "R10 loop zero", {30'h0, rx1_bit, rx2_bit}, 32'h1);
        selftest_n = 1'b1; #1;
        chk(!rx1_bit && rx2_bit, "R10 line", {30'h0, rx1_bit, rx2_bit}, 32'h1);
        line1_in = 1'b1; line2_in = 1'b0; #1;
        chk(rx1_bit && !rx2_bit, "R10 line swap", {30'h0, rx1_bit, rx2_bit}, 32'h2);

        repeat (3) @(negedge clk);
        chk(txq.size() == 0, "R5 all forwarded", txq.size(), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule